// File: doc/BRIEF.md
# Random Latency Timestamp Generator

This block gives every incoming memory transaction its own latency instead of a single fixed one. A free-running pseudo-random generator picks one slot of a delay table. The picked delay is added to the current value of a free-running time counter, and the sum is sent on as a transmit timestamp together with the transaction's ID. A downstream scheduler can then release each transaction when its timestamp is reached. Spread over many accesses, this models the varying access latency of a real memory.

The table comes out of reset with a bell-shaped profile. Each slot holds a base delay plus a step multiplied by the number of set bits in its index. Because the index is drawn uniformly, the delays that result follow a binomial distribution, which is close to Gaussian. The profile can be changed at run time through a simple write port. The generator advances only when a request is taken, so two back-to-back requests get independent draws, and idle cycles never use up draws.

Top module: `rand_delay_stamper`

## Requirements
- R1: After reset `rsp_valid` is 0. The generator holds the seed `SEED` (default 16'hACE1), so the first request after reset reads table slot `SEED[IDX_W-1:0]` (slot 33 by default).
- R2: `rsp_valid` is high in the cycle after a cycle in which `req_valid` was sampled high, and low otherwise. `rsp_id` then equals the `req_id` of that request.
- R3: For a request, `rsp_ts` = `now_time` + table[slot] modulo 2^TIME_W. Both values are taken in the cycle the request is sampled, and the slot is the generator's low `IDX_W` bits in that cycle.
- R4: The generator is a 16-bit right-shifting Galois LFSR with feedback mask 16'hB400. When the bit shifted out is 1, the next state is (state>>1)^16'hB400; otherwise it is state>>1. It advances exactly once per accepted request and holds on cycles without a request.
- R5: After reset, table slot i holds `BASE_DLY + STEP_DLY * popcount(i)`. The defaults are BASE_DLY=40 and STEP_DLY=12.
- R6: When `tbl_we` is high, `tbl_wdata` is written to slot `tbl_addr` at that clock edge. Requests in later cycles that draw this slot use the new value.
- R7: When a request and a write to the slot it draws fall in the same cycle, the request uses the old value of that slot.
- R8: The timestamp sum wraps modulo 2^TIME_W with no saturation. For example, 32'hFFFFFFF0 + 64 gives 32'h00000030.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one transaction per cycle |
| req_id | input | ID_W | Transaction ID |
| now_time | input | TIME_W | Current free-running time |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IDX_W | Table slot to write |
| tbl_wdata | input | DELAY_W | Delay value to write |
| rsp_valid | output | 1 | Stamped transaction strobe |
| rsp_id | output | ID_W | ID of the stamped transaction |
| rsp_ts | output | TIME_W | Transmit timestamp |

## Verification
The hardest case to reach is a table write to exactly the slot that a same-cycle request draws (R7). That slot depends on the hidden generator state. The bench keeps its own model of the LFSR, predicts the next slot, and aims directed writes at it in the same cycle as a request. The random phase also writes, with raised probability, to the slot it predicts for the next draw. A wrap-around time value near the top of the counter range exercises R8.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

   // Bell-shaped default profile: delay grows with the number of set bits
   function automatic int unsigned profile_delay(input int unsigned idx,
                                                 input int unsigned base,
                                                 input int unsigned step);
      int unsigned ones;
      ones = 0;
      for (int b = 0; b < 32; b++) begin
         ones = ones + ((idx >> b) & 1);
      end
      return base + step * ones;
   endfunction

   // One advance of a right-shifting Galois LFSR
   function automatic logic [15:0] galois_next16(input logic [15:0] s,
                                                 input logic [15:0] mask);
      return s[0] ? ((s >> 1) ^ mask) : (s >> 1);
   endfunction

endpackage

// File: rtl/stamp_lfsr.sv
module stamp_lfsr #(
   parameter int          LFSR_W = 16,
   parameter logic [15:0] MASK   = 16'hB400,
   parameter logic [15:0] SEED   = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [LFSR_W-1:0] state
);
   import stamp_pkg::*;

   if (LFSR_W != 16) begin : g_bad_width
      $error("stamp_lfsr: only a 16-bit generator is provided");
   end
   if (SEED == 16'h0000) begin : g_bad_seed
      $error("stamp_lfsr: seed must be nonzero");
   end

   logic [LFSR_W-1:0] nxt;

   always_comb begin
      nxt = galois_next16(state, MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (adv) begin
         state <= nxt;
      end
   end

   // R4
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state));
   // R4
   moves_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> state != $past(state));
   // R4
   never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/stamp_delay_table.sv
module stamp_delay_table #(
   parameter int DEPTH    = 64,
   parameter int DELAY_W  = 16,
   parameter int BASE_DLY = 40,
   parameter int STEP_DLY = 12,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   waddr,
   input  logic [DELAY_W-1:0] wdata,
   input  logic [IDX_W-1:0]   raddr,
   output logic [DELAY_W-1:0] rdata
);
   import stamp_pkg::*;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("stamp_delay_table: depth must be a power of two");
   end
   if (DEPTH > 4096) begin : g_too_deep
      $error("stamp_delay_table: depth too large for a register table");
   end

   logic [DELAY_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [DELAY_W-1:0] INIT =
         DELAY_W'(profile_delay(i, BASE_DLY, STEP_DLY));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot[i] <= INIT;
         end else if (we && waddr == IDX_W'(i)) begin
            slot[i] <= wdata;
         end
      end
   end

   // Combinational read sees the contents before this edge's write
   always_comb begin
      rdata = slot[raddr];
   end

   // R6
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> slot[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/stamp_issue.sv
module stamp_issue #(
   parameter int ID_W    = 8,
   parameter int TIME_W  = 32,
   parameter int DELAY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ID_W-1:0]    req_id,
   input  logic [TIME_W-1:0]  now_time,
   input  logic [DELAY_W-1:0] delay,
   output logic               rsp_valid,
   output logic [ID_W-1:0]    rsp_id,
   output logic [TIME_W-1:0]  rsp_ts
);
   if (DELAY_W > TIME_W) begin : g_bad_widths
      $error("stamp_issue: delay wider than time counter");
   end

   logic [TIME_W-1:0] delay_ext;
   logic [TIME_W-1:0] sum;

   if (DELAY_W == TIME_W) begin : g_same_w
      assign delay_ext = delay;
   end else begin : g_zero_ext
      assign delay_ext = {{(TIME_W-DELAY_W){1'b0}}, delay};
   end

   always_comb begin
      sum = now_time + delay_ext;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_ts    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_id <= req_id;
            rsp_ts <= sum;
         end
      end
   end

   // R2
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid && rsp_id == $past(req_id));
   // R2
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R3
   stamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_ts == TIME_W'($past(now_time) + TIME_W'($past(delay))));

endmodule

// File: rtl/rand_delay_stamper.sv
module rand_delay_stamper #(
   parameter int          ID_W     = 8,
   parameter int          TIME_W   = 32,
   parameter int          DELAY_W  = 16,
   parameter int          DEPTH    = 64,
   parameter int          LFSR_W   = 16,
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter int          BASE_DLY = 40,
   parameter int          STEP_DLY = 12,
   localparam int         IDX_W    = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ID_W-1:0]    req_id,
   input  logic [TIME_W-1:0]  now_time,
   input  logic               tbl_we,
   input  logic [IDX_W-1:0]   tbl_addr,
   input  logic [DELAY_W-1:0] tbl_wdata,
   output logic               rsp_valid,
   output logic [ID_W-1:0]    rsp_id,
   output logic [TIME_W-1:0]  rsp_ts
);
   if (IDX_W > LFSR_W) begin : g_bad_index
      $error("rand_delay_stamper: table index wider than generator");
   end

   logic [LFSR_W-1:0]  rng;
   logic [IDX_W-1:0]   pick;
   logic [DELAY_W-1:0] delay;

   stamp_lfsr #(
      .LFSR_W (LFSR_W),
      .MASK   (16'hB400),
      .SEED   (SEED)
   ) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (req_valid),
      .state (rng)
   );

   assign pick = rng[IDX_W-1:0];

   stamp_delay_table #(
      .DEPTH    (DEPTH),
      .DELAY_W  (DELAY_W),
      .BASE_DLY (BASE_DLY),
      .STEP_DLY (STEP_DLY)
   ) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (pick),
      .rdata (delay)
   );

   stamp_issue #(
      .ID_W    (ID_W),
      .TIME_W  (TIME_W),
      .DELAY_W (DELAY_W)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_id    (req_id),
      .now_time  (now_time),
      .delay     (delay),
      .rsp_valid (rsp_valid),
      .rsp_id    (rsp_id),
      .rsp_ts    (rsp_ts)
   );

   // R7
   old_value_on_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tbl_we && tbl_addr == pick && tbl_wdata != delay)
         |=> rsp_ts != TIME_W'($past(now_time) + TIME_W'($past(tbl_wdata))));

endmodule

// File: tb/sim_rand_delay_stamper.sv
module sim_rand_delay_stamper;
   localparam int ID_W = 8, TIME_W = 32, DELAY_W = 16, DEPTH = 64, IDX_W = 6;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               req_valid;
   logic [ID_W-1:0]    req_id;
   logic [TIME_W-1:0]  now_time;
   logic               tbl_we;
   logic [IDX_W-1:0]   tbl_addr;
   logic [DELAY_W-1:0] tbl_wdata;
   logic               rsp_valid;
   logic [ID_W-1:0]    rsp_id;
   logic [TIME_W-1:0]  rsp_ts;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0]        m_lfsr;
   logic [DELAY_W-1:0] m_tbl [DEPTH];
   logic               e_valid;
   logic [ID_W-1:0]    e_id;
   logic [TIME_W-1:0]  e_ts;

   always #4 clk = ~clk;

   rand_delay_stamper u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .now_time(now_time), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
      .rsp_ts(rsp_ts));

   function automatic logic [15:0] bench_step(input logic [15:0] s);
      logic [15:0] r;
      r = {1'b0, s[15:1]};
      if (s[0]) r = r ^ 16'hB400;
      return r;
   endfunction

   function automatic logic [DELAY_W-1:0] bench_profile(input int i);
      int c;
      c = 0;
      for (int b = 0; b < IDX_W; b++) c += (i >> b) & 1;
      return DELAY_W'(40 + 12 * c);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, model, check after the edge
   task automatic cyc(input bit rq, input logic [ID_W-1:0] id,
                      input logic [TIME_W-1:0] t, input bit we,
                      input logic [IDX_W-1:0] wa, input logic [DELAY_W-1:0] wd,
                      input string tag);
      req_valid = rq; req_id = id; now_time = t;
      tbl_we = we; tbl_addr = wa; tbl_wdata = wd;
      e_valid = rq;
      if (rq) begin
         e_id = id;
         e_ts = t + TIME_W'(m_tbl[m_lfsr[IDX_W-1:0]]);
         m_lfsr = bench_step(m_lfsr);
      end
      if (we) m_tbl[wa] = wd;
      @(posedge clk);
      #2;
      check(rsp_valid == e_valid, {tag, " R2 valid"}, 64'(rsp_valid), 64'(e_valid));
      if (e_valid) begin
         check(rsp_id == e_id, {tag, " R2 id"}, 64'(rsp_id), 64'(e_id));
         check(rsp_ts == e_ts, {tag, " R3 ts"}, 64'(rsp_ts), 64'(e_ts));
      end
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [TIME_W-1:0] t;
      logic [IDX_W-1:0]  nx;
      int unsigned       seed_dummy;
      rst_n = 1'b0; req_valid = 0; req_id = 0; now_time = 0;
      tbl_we = 0; tbl_addr = 0; tbl_wdata = 0;
      m_lfsr = 16'hACE1;
      for (int i = 0; i < DEPTH; i++) m_tbl[i] = bench_profile(i);
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: no valid out of reset
      check(rsp_valid == 1'b0, "R1 reset valid", 64'(rsp_valid), 64'd0);
      // R1 R5: first draw is slot 33, delay 40+12*2 = 64
      cyc(1, 8'h11, 32'd1000, 0, 0, 0, "R1 first draw");
      check(rsp_ts == 32'd1064, "R1 R5 seed slot", 64'(rsp_ts), 64'd1064);
      // R4: idle cycles do not consume draws
      repeat (5) cyc(0, 0, 32'd1001, 0, 0, 0, "R4 idle");
      cyc(1, 8'h22, 32'd2000, 0, 0, 0, "R4 after idle");
      // R4: back-to-back requests
      for (int k = 0; k < 6; k++) cyc(1, 8'(k), 32'd3000 + 32'(k), 0, 0, 0, "R4 b2b");
      // R5: sweep profile at a fixed time
      for (int k = 0; k < 20; k++) cyc(1, 8'hA0, 32'd0, 0, 0, 0, "R5 profile");
      // R8: wrap of the sum
      nx = m_lfsr[IDX_W-1:0];
      cyc(0, 0, 0, 1, nx, 16'd64, "R8 setup");
      cyc(1, 8'h5A, 32'hFFFFFFF0, 0, 0, 0, "R8 wrap");
      check(rsp_ts == 32'h00000030, "R8 wrap value", 64'(rsp_ts), 64'h30);
      // R6: write then a later request draws the new value
      nx = m_lfsr[IDX_W-1:0];
      cyc(0, 0, 0, 1, nx, 16'hBEEF, "R6 write");
      cyc(1, 8'h66, 32'd500, 0, 0, 0, "R6 use");
      check(rsp_ts == 32'd500 + 32'hBEEF, "R6 new value", 64'(rsp_ts), 64'(32'd500 + 32'hBEEF));
      // R7: clash, old value used
      nx = m_lfsr[IDX_W-1:0];
      t = 32'd700 + 32'(m_tbl[nx]);
      cyc(1, 8'h77, 32'd700, 1, nx, 16'h1234, "R7 clash");
      check(rsp_ts == t, "R7 old value", 64'(rsp_ts), 64'(t));
      // Random phase
      t = 32'd10000;
      for (int k = 0; k < 3000; k++) begin
         bit rq, we;
         logic [IDX_W-1:0] wa;
         rq = ($urandom % 4) != 0;
         we = ($urandom % 5) == 0;
         wa = (($urandom % 2) == 0) ? m_lfsr[IDX_W-1:0] : IDX_W'($urandom);
         t = t + 32'($urandom % 3);
         if (($urandom % 200) == 0) t = 32'hFFFFFF00 + 32'($urandom % 256);
         cyc(rq, 8'($urandom), t, we, wa, 16'($urandom), "R3 R6 R7 random");
      end
      // R1: reset restores seed and profile
      rst_n = 1'b0;
      @(posedge clk); #2;
      check(rsp_valid == 1'b0, "R1 reset again", 64'(rsp_valid), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_lfsr = 16'hACE1;
      for (int i = 0; i < DEPTH; i++) m_tbl[i] = bench_profile(i);
      cyc(1, 8'h01, 32'd50, 0, 0, 0, "R1 R5 after reset");
      check(rsp_ts == 32'd114, "R1 R5 reseed", 64'(rsp_ts), 64'd114);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule